// File: doc/BRIEF.md
# Flash Command Sequencer with Data Polling

This block turns a high-level flash request into the bus writes that a byte-wide flash device needs before it starts an embedded operation. It then watches the device until that operation is over. Three operations are supported: byte program (target address and data byte), sector erase (a mask of one or more of the eight equal sectors) and chip erase. The block emits each write as one request on a generic bus port and waits for that port's acknowledge. A separate bus access engine produces the real strobe timing.

The port is as wide as several byte lanes side by side, and each lane is a separate flash device. A lane mask given with the command selects which devices take part. Every write puts the same byte on all lanes and enables only the selected lanes. While the embedded operation runs, the device returns the complement of the final bit 7. The block keeps reading the same address until every selected lane shows the expected final byte. It then pulses `done`. If a per-operation cycle limit is reached first, it pulses `tmo` instead. In both cases it returns to idle.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset `busy`, `bus_req`, `done` and `tmo` are all 0.
- R2: Op code 0 (program) issues four writes in this order: AAh to 5555h, 55h to 2AAAh, A0h to 5555h, then the command data byte to the command address. Each write uses `bus_be` equal to the lane mask and carries the byte replicated on every lane of `bus_wdata`.
- R3: Op code 1 (sector erase) issues AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h and 55h@2AAAh. It then writes 30h once per selected sector, in ascending sector order. Sector s has the address whose top three bits are s and whose other bits are zero.
- R4: Op code 2 (chip erase) issues the same first five writes as R3, then writes 10h to 5555h.
- R5: After the last write, the block reads repeatedly with `bus_we`=0. A program polls the target address. A sector erase polls the address of the highest selected sector. A chip erase polls 5555h.
- R6: A program completes on the first read in which every selected lane returns the programmed byte. An erase completes when every selected lane returns FFh. A read in which bit 7 still shows the complement does not complete the operation. `done` pulses for one cycle, in the cycle after the completing acknowledge.
- R7: Lanes outside the lane mask have no effect on completion.
- R8: If polling has not completed after PROG_TMO cycles (program) or ERASE_TMO cycles (erase), the block pulses `tmo` for one cycle, does not pulse `done`, and returns to idle. `tmo` appears PROG_TMO+1 or ERASE_TMO+1 cycles after the cycle in which the last write is acknowledged.
- R9: `busy` rises in the cycle after a command is accepted and stays high until the cycle in which `done` or `tmo` is shown, where it is 0. Commands presented while busy are ignored.
- R10: Op code 3, and a sector erase with an all-zero sector mask, are ignored: no bus request is made and `busy` stays 0.
- R11: A pending write request keeps its address, data, lane enables and direction stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command request, taken only when idle |
| cmd_op | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 ignored |
| cmd_addr | input | ADDR_W | Program target address |
| cmd_data | input | 8 | Program data byte |
| cmd_sectors | input | SECTORS | Sectors to erase, one bit per sector |
| cmd_lanes | input | LANES | Byte lanes (devices) taking part |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| tmo | output | 1 | One-cycle pulse on timeout |
| bus_req | output | 1 | Bus transfer request, held until acknowledged |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | ADDR_W | Transfer address |
| bus_be | output | LANES | Lane enables |
| bus_wdata | output | 8*LANES | Write data, byte replicated on every lane |
| bus_rdata | input | 8*LANES | Read data, valid with `bus_ack` on reads |
| bus_ack | input | 1 | Transfer complete; consumed at the clock edge |

## Verification
Each result is due a fixed number of cycles after the acknowledge that causes it. `busy` is due one cycle after the accepting edge. `done` is due one cycle after the completing read is acknowledged. `tmo` is due exactly the limit plus one cycles after the last write is acknowledged. The bench stands in for the bus engine and the flash devices, with a chosen acknowledge latency and a chosen number of in-progress reads. It records the cycle of every acknowledge it gives and checks each result in exactly that later cycle. It also checks `busy` on every cycle between acceptance and completion, and compares every write and poll address against a sequence it builds itself.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int          ADDR_W    = 19,
  parameter int          LANES     = 4,
  parameter int          SECTORS   = 8,
  parameter logic [31:0] PROG_TMO  = 32'd60000,
  parameter logic [31:0] ERASE_TMO = 32'd3000000000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [1:0]           cmd_op,
  input  logic [ADDR_W-1:0]    cmd_addr,
  input  logic [7:0]           cmd_data,
  input  logic [SECTORS-1:0]   cmd_sectors,
  input  logic [LANES-1:0]     cmd_lanes,
  output logic                 busy,
  output logic                 done,
  output logic                 tmo,
  output logic                 bus_req,
  output logic                 bus_we,
  output logic [ADDR_W-1:0]    bus_addr,
  output logic [LANES-1:0]     bus_be,
  output logic [8*LANES-1:0]   bus_wdata,
  input  logic [8*LANES-1:0]   bus_rdata,
  input  logic                 bus_ack
);
  localparam int          SEC_W   = $clog2(SECTORS);
  localparam int          OFS_W   = ADDR_W - SEC_W;
  localparam logic [31:0] TMO_MAX = (PROG_TMO > ERASE_TMO) ? PROG_TMO : ERASE_TMO;
  localparam int          CNT_W   = $clog2(TMO_MAX) + 1;
  localparam logic [ADDR_W-1:0] UNLK_A = ADDR_W'(16'h5555);
  localparam logic [ADDR_W-1:0] UNLK_B = ADDR_W'(16'h2AAA);
  localparam logic [1:0] OP_PROG = 2'd0, OP_SECT = 2'd1, OP_CHIP = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_WR, S_POLL} state_t;

  state_t             state;
  logic [1:0]         op;
  logic [ADDR_W-1:0]  tgt;
  logic [7:0]         dat;
  logic [SECTORS-1:0] secs;
  logic [LANES-1:0]   lanes;
  logic [2:0]         step;
  logic [SEC_W-1:0]   cur_sec;
  logic [CNT_W-1:0]   cnt;

  logic [SEC_W-1:0]   nxt;
  logic [SECTORS-1:0] rem;
  logic [ADDR_W-1:0]  wr_addr, poll_addr;
  logic [7:0]         wr_byte, want;
  logic               last_wr, poll_ok, accept;
  logic [CNT_W-1:0]   lim_m1;

  assign accept = cmd_valid && (cmd_op == OP_PROG || cmd_op == OP_CHIP ||
                                (cmd_op == OP_SECT && |cmd_sectors));

  always_comb begin
    nxt = '0;
    for (int i = SECTORS - 1; i >= 0; i--)
      if (secs[i]) nxt = SEC_W'(i);
  end
  assign rem = secs & ~(SECTORS'(1) << nxt);

  always_comb begin
    wr_addr = UNLK_A;
    wr_byte = 8'hAA;
    case (step)
      3'd1: begin wr_addr = UNLK_B; wr_byte = 8'h55; end
      3'd2: wr_byte = (op == OP_PROG) ? 8'hA0 : 8'h80;
      3'd3: if (op == OP_PROG) begin wr_addr = tgt; wr_byte = dat; end
      3'd4: begin wr_addr = UNLK_B; wr_byte = 8'h55; end
      3'd5: if (op == OP_SECT) begin
              wr_addr = {nxt, {OFS_W{1'b0}}};
              wr_byte = 8'h30;
            end else wr_byte = 8'h10;
      default: ;
    endcase
  end

  assign last_wr   = (op == OP_PROG) ? (step == 3'd3)
                                     : (step == 3'd5 && (op == OP_CHIP || rem == '0));
  assign poll_addr = (op == OP_PROG) ? tgt :
                     (op == OP_CHIP) ? UNLK_A : {cur_sec, {OFS_W{1'b0}}};
  assign want      = (op == OP_PROG) ? dat : 8'hFF;
  assign lim_m1    = (op == OP_PROG) ? CNT_W'(PROG_TMO - 32'd1) : CNT_W'(ERASE_TMO - 32'd1);

  always_comb begin
    poll_ok = 1'b1;
    for (int l = 0; l < LANES; l++)
      if (lanes[l] && bus_rdata[8*l +: 8] != want) poll_ok = 1'b0;
  end

  assign busy      = (state != S_IDLE);
  assign bus_req   = busy;
  assign bus_we    = (state == S_WR);
  assign bus_addr  = (state == S_POLL) ? poll_addr : wr_addr;
  assign bus_be    = lanes;
  assign bus_wdata = {LANES{wr_byte}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      op      <= OP_PROG;
      tgt     <= '0;
      dat     <= '0;
      secs    <= '0;
      lanes   <= '0;
      step    <= '0;
      cur_sec <= '0;
      cnt     <= '0;
      done    <= 1'b0;
      tmo     <= 1'b0;
    end else begin
      done <= 1'b0;
      tmo  <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          state <= S_WR;
          op    <= cmd_op;
          tgt   <= cmd_addr;
          dat   <= cmd_data;
          secs  <= cmd_sectors;
          lanes <= cmd_lanes;
          step  <= '0;
        end
        S_WR: if (bus_ack) begin
          if (op == OP_SECT && step == 3'd5) begin
            secs    <= rem;
            cur_sec <= nxt;
          end else step <= step + 3'd1;
          if (last_wr) begin
            state <= S_POLL;
            cnt   <= '0;
          end
        end
        S_POLL: begin
          if (bus_ack && poll_ok) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else if (cnt == lim_m1) begin
            state <= S_IDLE;
            tmo   <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r11_write_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WR && !bus_ack) |=> bus_req && bus_we && $stable(bus_addr) &&
                                    $stable(bus_wdata) && $stable(bus_be));
  a_r8_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && tmo));
  a_r9_idle_at_finish: assert property (@(posedge clk) disable iff (!rst_n)
    (done || tmo) |-> !busy && !bus_req);
  a_r9_fall_reported: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done || tmo);
  a_r10_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && (cmd_op == 2'd3 || (cmd_op == OP_SECT && cmd_sectors == '0)))
      |=> !busy);
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_POLL) |-> cnt <= lim_m1);
  a_r2_first_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> bus_we && bus_addr == UNLK_A && bus_wdata[7:0] == 8'hAA);
endmodule

// File: tb/flash_cmd_seq_tb.sv
`timescale 1ns/100ps
module flash_cmd_seq_tb;
  localparam int AW = 19, LN = 4, NS = 8;
  localparam int PT = 40, ET = 60;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, cmd_valid = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0] cmd_data = '0;
  logic [NS-1:0] cmd_sectors = '0;
  logic [LN-1:0] cmd_lanes = '0;
  logic busy, done, tmo, bus_req, bus_we;
  logic [AW-1:0] bus_addr;
  logic [LN-1:0] bus_be;
  logic [8*LN-1:0] bus_wdata, bus_rdata = '0;
  logic bus_ack = 1'b0;

  flash_cmd_seq #(.ADDR_W(AW), .LANES(LN), .SECTORS(NS),
                  .PROG_TMO(32'(PT)), .ERASE_TMO(32'(ET))) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_sectors(cmd_sectors),
    .cmd_lanes(cmd_lanes), .busy(busy), .done(done), .tmo(tmo),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack));

  int cyc = 0, n_cmp = 0, n_bad = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  logic [AW+8+LN-1:0] exq[$];
  string ctag = "R1";
  bit f_prog;
  logic [7:0] f_dat;
  logic [LN-1:0] f_lanes;
  logic [AW-1:0] f_poll;
  int f_busy = 0, lat = 0, n_rd = 0, rd_cyc = 0, wr_cyc = 0, wt = 0;
  logic [AW-1:0] h_a;
  logic [8*LN-1:0] h_d;

  always @(negedge clk) begin
    if (bus_ack) bus_ack = 1'b0;
    else if (bus_req) begin
      if (wt == 0) begin h_a = bus_addr; h_d = bus_wdata; end
      if (wt >= lat) begin
        wt = 0;
        bus_ack = 1'b1;
        chk(bus_addr == h_a && bus_wdata == h_d, {ctag, "/R11"}, "request held", bus_addr, h_a);
        if (bus_we) begin
          wr_cyc = cyc;
          chk(bus_wdata == {LN{bus_wdata[7:0]}}, {ctag, "/R2"}, "lane replication", bus_wdata, 0);
          if (exq.size() == 0) chk(0, ctag, "unexpected write", bus_addr, 0);
          else begin
            logic [AW+8+LN-1:0] e;
            e = exq.pop_front();
            chk({bus_addr, bus_wdata[7:0], bus_be} == e, ctag, "write addr/data/be",
                {bus_addr, bus_wdata[7:0], bus_be}, e);
          end
        end else begin
          n_rd++;
          rd_cyc = cyc;
          chk(bus_addr == f_poll, {ctag, "/R5"}, "poll address", bus_addr, f_poll);
          for (int l = 0; l < LN; l++) begin
            logic [7:0] ip, fin;
            ip  = f_prog ? {~f_dat[7], f_dat[6:0]} : 8'h7F;
            fin = f_prog ? f_dat : 8'hFF;
            bus_rdata[8*l +: 8] = (f_busy > 0 || !f_lanes[l]) ? ip : fin;
          end
          if (f_busy > 0) f_busy--;
        end
      end else wt++;
    end else wt = 0;
  end

  task automatic run(string tag, logic [1:0] op, logic [AW-1:0] a, logic [7:0] d,
                     logic [NS-1:0] secs, logic [LN-1:0] lanes, int latency,
                     int nbusy, bit junk, bit exp_tmo);
    int fin_cyc;
    ctag = tag; lat = latency; f_prog = (op == 2'd0); f_dat = d;
    f_lanes = lanes; f_busy = nbusy; n_rd = 0;
    exq.push_back({AW'(16'h5555), 8'hAA, lanes});
    exq.push_back({AW'(16'h2AAA), 8'h55, lanes});
    if (op == 2'd0) begin
      exq.push_back({AW'(16'h5555), 8'hA0, lanes});
      exq.push_back({a, d, lanes});
      f_poll = a;
    end else begin
      exq.push_back({AW'(16'h5555), 8'h80, lanes});
      exq.push_back({AW'(16'h5555), 8'hAA, lanes});
      exq.push_back({AW'(16'h2AAA), 8'h55, lanes});
      if (op == 2'd2) begin
        exq.push_back({AW'(16'h5555), 8'h10, lanes});
        f_poll = AW'(16'h5555);
      end else
        for (int s = 0; s < NS; s++)
          if (secs[s]) begin
            exq.push_back({3'(s), 16'h0, 8'h30, lanes});
            f_poll = {3'(s), 16'h0};
          end
    end
    @(negedge clk);
    cmd_op = op; cmd_addr = a; cmd_data = d; cmd_sectors = secs; cmd_lanes = lanes;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 1'b1, {tag, "/R9"}, "busy after accept", busy, 1);
    for (int k = 0; k < 4000; k++) begin
      if (done || tmo) break;
      chk(busy == 1'b1, {tag, "/R9"}, "busy while running", busy, 1);
      if (junk) begin
        cmd_valid = 1'b1; cmd_op = 2'(k % 3); cmd_addr = AW'(k * 77);
        cmd_data = 8'(k); cmd_sectors = 8'hFF; cmd_lanes = 4'hF;
      end
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    fin_cyc = cyc;
    if (exp_tmo) begin
      chk(tmo && !done, {tag, "/R8"}, "timeout pulse", {done, tmo}, 1);
      chk(fin_cyc - wr_cyc == (f_prog ? PT : ET) + 1, {tag, "/R8"}, "timeout delay",
          fin_cyc - wr_cyc, (f_prog ? PT : ET) + 1);
    end else begin
      chk(done && !tmo, {tag, "/R6"}, "done pulse", {done, tmo}, 2);
      chk(n_rd == nbusy + 1, {tag, "/R6"}, "poll read count", n_rd, nbusy + 1);
      chk(fin_cyc == rd_cyc + 1, {tag, "/R6"}, "done delay", fin_cyc - rd_cyc, 1);
    end
    chk(busy == 1'b0, {tag, "/R9"}, "busy low at finish", busy, 0);
    chk(exq.size() == 0, tag, "writes left unissued", exq.size(), 0);
    exq.delete();
    @(negedge clk);
    chk(!done && !tmo && !busy, {tag, "/R9"}, "single-cycle result", {busy, done, tmo}, 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #500000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !bus_req && !done && !tmo, "R1", "reset outputs",
        {busy, bus_req, done, tmo}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !bus_req && !done && !tmo, "R1", "after reset",
        {busy, bus_req, done, tmo}, 0);

    run("R2/R7 prog lane0",      2'd0, 19'h12345, 8'h5A, 8'h00, 4'b0001, 0, 3, 0, 0);
    run("R2/R9 prog junk",       2'd0, 19'h7FFFF, 8'hC3, 8'h00, 4'b1111, 2, 5, 1, 0);
    run("R2/R7 prog bit7 low",   2'd0, 19'h00001, 8'h12, 8'h00, 4'b0110, 1, 0, 0, 0);
    run("R3 sector one",         2'd1, 19'h0,     8'h00, 8'h01, 4'b0011, 1, 4, 0, 0);
    run("R3/R5 sectors multi",   2'd1, 19'h0,     8'h00, 8'hA4, 4'b1111, 0, 2, 1, 0);
    run("R4/R7 chip",            2'd2, 19'h0,     8'h00, 8'h00, 4'b1100, 3, 6, 0, 0);
    run("R8 prog timeout",       2'd0, 19'h2AAAA, 8'h99, 8'h00, 4'b0001, 1, 1000000, 0, 1);
    run("R8 chip timeout",       2'd2, 19'h0,     8'h00, 8'h00, 4'b1111, 0, 1000000, 0, 1);

    ctag = "R10";
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd3; cmd_lanes = 4'hF;
    @(negedge clk);
    chk(!busy && !bus_req, "R10", "op 3 ignored", {busy, bus_req}, 0);
    cmd_op = 2'd1; cmd_sectors = '0;
    @(negedge clk);
    chk(!busy && !bus_req, "R10", "empty sector mask ignored", {busy, bus_req}, 0);
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !bus_req && !done && !tmo, "R10", "still idle",
        {busy, bus_req, done, tmo}, 0);

    run("R6 after reject",       2'd0, 19'h04040, 8'hFF, 8'h00, 4'b1000, 0, 1, 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule